// File: doc/BRIEF.md
# Floating-Point Result Scoreboard

This block tracks, for each floating-point register, whether an arithmetic result aimed at it is still in flight. Each clock it accepts at most one arithmetic issue. An issue carries a destination register index and a latency. The destination stays pending until the publish cycle, which is the issue cycle plus the latency. From that cycle on, the register can be read.

A consumer presents up to two source register indices, a use bit for each source, and a dependency role. When the consumer's role is at or above a threshold and an enabled source names a pending register, the block raises `stall`. The surrounding pipeline holds that consumer back until `stall` drops. Meanwhile the countdowns keep running. Readers whose role is below the threshold are never stalled here, because a separate hazard check handles them.

A dependent chain of latency-3 operations advances once every three cycles. Independent operations can issue on every clock.

Top module: `fp_result_scoreboard`

## Requirements
- R1: A synchronous active-high `rst` clears every pending result. In the first cycle after reset, no register is reported pending, including one that was issued just before reset.
- R2: An issue with latency L (1 to 3) to register d in cycle N causes a dependent consumer of d to be stalled in cycles N through N+L-1 and released in cycle N+L. A dependent chain of latency-3 operations therefore issues once every 3 cycles.
- R3: A consumer that reads register d in the same cycle that an issue with nonzero latency targets d is stalled in that cycle.
- R4: A consumer whose role is 0 or 1 is never stalled. Only roles 2 and 3 are treated as dependent.
- R5: `stall` is low whenever `rd_valid` is low. A source whose `rd_use` bit is 0 never causes a stall.
- R6: Issues may arrive every clock. An issue to one register never stalls a consumer that reads only other registers.
- R7: An issue to a register that is already pending restarts its countdown from the new latency, whether that latency is longer or shorter than what remains.
- R8: Source 0 sits in `rd_src` bits [2:0] and source 1 in bits [5:3]. The consumer is stalled if either enabled source is pending.
- R9: An issue with latency 0 leaves its destination readable in the issue cycle and in every later cycle.
- R10: While a consumer is stalled, the countdown keeps decrementing, so a continuously stalled consumer is released on the publish cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | An arithmetic op issues this cycle |
| iss_dst | input | 3 | Destination register index of the issuing op |
| iss_lat | input | 2 | Result latency in cycles (0 to 3) |
| rd_valid | input | 1 | A consumer is requesting its operands |
| rd_role | input | 2 | Dependency role of the consumer |
| rd_src | input | 6 | Two packed source indices; source 0 in [2:0], source 1 in [5:3] |
| rd_use | input | 2 | Per-source enable; bit i qualifies source i |
| stall | output | 1 | Dependent consumer must wait this cycle |

## Verification
The bench builds the block with its default parameters: eight registers, a maximum latency of three, two source ports and a role threshold of two. With these values every latency from 0 to 3 can be driven through the 2-bit latency input, and both role classes on each side of the threshold can be exercised. The bench drives a dependent chain and an independent stream so that it can observe the one-per-three and one-per-clock issue rates directly at the stall output. It also reloads a register while it is still pending, both with a longer and with a shorter latency.

// File: rtl/fp_result_scoreboard.sv
module fp_result_scoreboard #(
  parameter int NREG     = 8,
  parameter int MAX_LAT  = 3,
  parameter int NSRC     = 2,
  parameter int ROLE_W   = 2,
  parameter int ROLE_MIN = 2,
  localparam int IW = $clog2(NREG),
  localparam int CW = $clog2(MAX_LAT + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 iss_valid,
  input  logic [IW-1:0]        iss_dst,
  input  logic [CW-1:0]        iss_lat,
  input  logic                 rd_valid,
  input  logic [ROLE_W-1:0]    rd_role,
  input  logic [NSRC*IW-1:0]   rd_src,
  input  logic [NSRC-1:0]      rd_use,
  output logic                 stall
);

  logic [CW-1:0]   lat_eff;
  logic [CW-1:0]   remain [NREG];
  logic [NREG-1:0] hit;
  logic [NREG-1:0] pend;
  logic [NSRC-1:0] src_busy;
  logic            dependent;

  assign lat_eff   = (iss_lat > CW'(MAX_LAT)) ? CW'(MAX_LAT) : iss_lat;
  assign dependent = rd_valid && (rd_role >= ROLE_W'(ROLE_MIN));

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    assign hit[r]  = iss_valid && (lat_eff != '0) && (iss_dst == IW'(r));
    assign pend[r] = (remain[r] != '0) || hit[r];

    always_ff @(posedge clk) begin
      if (rst)                  remain[r] <= '0;
      else if (hit[r])          remain[r] <= lat_eff - CW'(1);
      else if (remain[r] != '0) remain[r] <= remain[r] - CW'(1);
    end

    // Countdown runs regardless of any consumer stall
    assert_countdown_R10: assert property (@(posedge clk) disable iff (rst)
      (remain[r] != '0 && !hit[r]) |=> (remain[r] == $past(remain[r]) - CW'(1)));

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (remain[r] == '0));

    assert_bounded_R2: assert property (@(posedge clk) disable iff (rst)
      remain[r] <= CW'(MAX_LAT - 1));
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign src_busy[s] = rd_use[s] && pend[rd_src[s*IW +: IW]];
  end

  assign stall = dependent && (|src_busy);

  assert_low_role_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_role < ROLE_W'(ROLE_MIN)) |-> !stall);

  assert_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> !stall);

  assert_same_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_role >= ROLE_W'(ROLE_MIN) && rd_use[0] && iss_valid &&
     iss_lat != '0 && rd_src[IW-1:0] == iss_dst) |-> stall);

endmodule

// File: tb/fp_result_scoreboard_test.sv
module fp_result_scoreboard_test;
  logic       clk = 0;
  logic       rst = 1;
  logic       iss_valid = 0;
  logic [2:0] iss_dst = 0;
  logic [1:0] iss_lat = 0;
  logic       rd_valid = 0;
  logic [1:0] rd_role = 0;
  logic [5:0] rd_src = 0;
  logic [1:0] rd_use = 0;
  logic       stall;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fp_result_scoreboard uut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_lat(iss_lat),
    .rd_valid(rd_valid), .rd_role(rd_role), .rd_src(rd_src), .rd_use(rd_use), .stall(stall));

  task automatic drive(input bit iv, input int d, input int l, input bit cv, input int role,
                       input int s0, input bit u0, input int s1, input bit u1);
    iss_valid = iv; iss_dst = 3'(d); iss_lat = 2'(l);
    rd_valid = cv; rd_role = 2'(role);
    rd_src = {3'(s1), 3'(s0)}; rd_use = {u1, u0};
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input string tag, input bit exp);
    #5;
    checks++;
    if (stall !== exp) begin
      fails++;
      $display("FAIL %s: stall=%b expected %b", tag, stall, exp);
    end
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (4) step();
  endtask

  task automatic t_reset();
    for (int r = 0; r < 8; r++) begin
      drive(0, 0, 0, 1, 3, r, 1, 0, 0);
      check($sformatf("R1 clear after reset r%0d", r), 0);
    end
    drive(1, 5, 3, 0, 0, 0, 0, 0, 0); step();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    rst = 1; step(); rst = 0;
    drive(0, 0, 0, 1, 2, 5, 1, 0, 0);
    check("R1 pending dropped by reset", 0);
    step();
  endtask

  task automatic t_latency();
    idle();
    drive(1, 1, 3, 1, 2, 1, 1, 0, 0); check("R3 same-cycle read", 1); step();
    drive(0, 0, 0, 1, 2, 1, 1, 0, 0); check("R2 lat3 N+1", 1); step();
    check("R10 lat3 N+2 still counting", 1); step();
    check("R2 lat3 released N+3", 0); step();
    idle();
    drive(1, 2, 1, 1, 3, 2, 1, 0, 0); check("R2 lat1 N", 1); step();
    drive(0, 0, 0, 1, 3, 2, 1, 0, 0); check("R2 lat1 released N+1", 0); step();
    idle();
    drive(1, 3, 2, 1, 2, 3, 1, 0, 0); check("R2 lat2 N", 1); step();
    drive(0, 0, 0, 1, 2, 3, 1, 0, 0); check("R2 lat2 N+1", 1); step();
    check("R2 lat2 released N+2", 0); step();
    idle();
    drive(1, 4, 0, 1, 2, 4, 1, 0, 0); check("R9 lat0 issue cycle", 0); step();
    drive(0, 0, 0, 1, 2, 4, 1, 0, 0); check("R9 lat0 next cycle", 0); step();
  endtask

  task automatic t_chain();
    int issued = 0, cyc = 0;
    int at[4];
    idle();
    while (issued < 4 && cyc < 40) begin
      drive(0, 0, 0, 1, 2, issued, issued > 0, 0, 0);
      #5;
      if (!stall) begin
        iss_valid = 1; iss_dst = 3'(issued + 1); iss_lat = 2'd3;
        at[issued] = cyc; issued++;
      end
      step(); cyc++;
    end
    for (int i = 0; i < 4; i++) begin
      checks++;
      if (at[i] != 3 * i) begin
        fails++;
        $display("FAIL R2 chain op%0d issued at %0d expected %0d", i, at[i], 3 * i);
      end
    end
  endtask

  task automatic t_indep();
    idle();
    for (int i = 0; i < 6; i++) begin
      drive(1, i, 3, 1, 2, 7, 1, 6, 1);
      check($sformatf("R6 independent op%0d", i), 0);
      step();
    end
  endtask

  task automatic t_role_use();
    idle();
    drive(1, 3, 3, 1, 0, 3, 1, 0, 0); check("R4 role0", 0); step();
    drive(0, 0, 0, 1, 1, 3, 1, 0, 0); check("R4 role1", 0); step();
    drive(0, 0, 0, 1, 3, 3, 1, 0, 0); check("R4 role3 stalls", 1); step();
    idle();
    drive(1, 4, 3, 0, 2, 4, 1, 0, 0); check("R5 rd_valid low", 0); step();
    drive(0, 0, 0, 1, 2, 4, 0, 4, 0); check("R5 use bits clear", 0); step();
    drive(0, 0, 0, 1, 2, 0, 1, 4, 1); check("R8 source1 busy", 1); step();
  endtask

  task automatic t_two_src_reload();
    idle();
    drive(1, 5, 3, 1, 2, 5, 1, 0, 1); check("R8 source0 busy", 1); step();
    drive(0, 0, 0, 1, 2, 0, 1, 5, 0); check("R8 source1 disabled", 0); step();
    idle();
    drive(1, 6, 3, 0, 0, 0, 0, 0, 0); step();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0); step();
    drive(1, 6, 3, 0, 0, 0, 0, 0, 0); step();
    drive(0, 0, 0, 1, 2, 6, 1, 0, 0); check("R7 reload longer N+3", 1); step();
    check("R7 reload longer N+4", 1); step();
    check("R7 reload longer released N+5", 0); step();
    idle();
    drive(1, 7, 3, 0, 0, 0, 0, 0, 0); step();
    drive(1, 7, 1, 0, 0, 0, 0, 0, 0); step();
    drive(0, 0, 0, 1, 2, 7, 1, 0, 0); check("R7 reload shorter released", 0); step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_latency();
    t_chain();
    t_indep();
    t_role_use();
    t_two_src_reload();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule